// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This block forms the memory effective address for a register-memory processor. It takes a base register value, an index register value, a two-bit scale code and a displacement field. A mode code picks which of these terms go into the sum. The displacement may be short or wide; a short displacement is sign-extended.

The address calculation is one combinational sum of up to three terms. The result is captured in an output register one cycle after a request strobe and is flagged by a result strobe. Instruction decode, register fetch and the memory access itself take place around this block.

Top module: `scaled_ea_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `res_valid` is 0 and `res_addr` is 0 until the first request.
- R2: A request sampled with `req_valid` = 1 on a rising clock edge produces its address on `res_addr` with `res_valid` = 1 after that same edge. `res_valid` is 0 after any edge where `req_valid` was 0.
- R3: The mode code 0 selects register indirect. The address is `base`, and `index`, `scale`, `disp` and `disp_wide` have no effect.
- R4: The mode code 1 selects base plus displacement. The address is `base` + the extended displacement, and `index` and `scale` have no effect.
- R5: When `disp_wide` = 0, only `disp[7:0]` is used, sign-extended to 32 bits, and `disp[31:8]` has no effect. When `disp_wide` = 1, all 32 bits of `disp` are used.
- R6: The mode code 2 selects base plus scaled index. The address is `base` + `index` × 2^`scale`, so scale codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8. The displacement has no effect.
- R7: The mode code 3 selects base + `index` × 2^`scale` + the extended displacement.
- R8: All address arithmetic wraps modulo 2^32, and bits shifted out of the scaled index are dropped.
- R9: After an edge with `req_valid` = 0, `res_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; the inputs below are sampled when it is 1 |
| req_mode | input | 2 | Mode code: bit 1 adds the scaled index, bit 0 adds the displacement |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index scale as a power of two (shift amount 0 to 3) |
| disp | input | 32 | Displacement field |
| disp_wide | input | 1 | 1: full 32-bit displacement; 0: sign-extended low byte |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_addr | output | 32 | Registered effective address |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 32-bit wide displacement, an 8-bit short displacement, a 2-bit scale and the staged log shifter. These values bring the full scale range into reach, including factor 8 pushing index bits past bit 31. They also cover the sign bit of the short displacement at 0x7F and 0x80 and the carry out of bit 31 when a large base meets a negative displacement. The short displacement is driven with nonzero upper bits to show that those bits are dropped. Idle gaps with changing inputs show that the held result does not move.

// File: rtl/ea_pkg.sv
package ea_pkg;
   // bit 1: add scaled index, bit 0: add displacement
   typedef enum logic [1:0] {
      EA_REG_IND       = 2'd0,
      EA_BASE_DISP     = 2'd1,
      EA_BASE_IDX      = 2'd2,
      EA_BASE_IDX_DISP = 2'd3
   } ea_mode_e;
endpackage

// File: rtl/ea_index_scaler.sv
module ea_index_scaler #(
   parameter int AW              = 32,
   parameter int SW              = 2,
   parameter int USE_LOG_SHIFTER = 1
) (
   input  logic [AW-1:0] idx_in,
   input  logic [SW-1:0] shamt,
   output logic [AW-1:0] idx_out
);
   if (SW < 1 || SW > 5) begin : g_bad_sw
      $error("ea_index_scaler: SW out of range");
   end

   if (USE_LOG_SHIFTER != 0) begin : g_log
      logic [AW-1:0] stage [SW+1];
      assign stage[0] = idx_in;
      for (genvar k = 0; k < SW; k++) begin : g_stage
         assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
      end
      assign idx_out = stage[SW];
   end else begin : g_direct
      assign idx_out = idx_in << shamt;
   end
endmodule

// File: rtl/ea_disp_extend.sv
module ea_disp_extend #(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int SDW = 8
) (
   input  logic [DW-1:0] disp_in,
   input  logic          wide,
   output logic [AW-1:0] disp_out
);
   if (DW > AW) begin : g_bad_dw
      $error("ea_disp_extend: DW wider than AW");
   end
   if (SDW < 1 || SDW >= DW) begin : g_bad_sdw
      $error("ea_disp_extend: SDW must be below DW");
   end

   logic [AW-1:0] wide_ext;
   logic [AW-1:0] short_ext;

   if (DW == AW) begin : g_same
      assign wide_ext = disp_in;
   end else begin : g_grow
      assign wide_ext = {{(AW-DW){disp_in[DW-1]}}, disp_in};
   end
   assign short_ext = {{(AW-SDW){disp_in[SDW-1]}}, disp_in[SDW-1:0]};

   assign disp_out = wide ? wide_ext : short_ext;
endmodule

// File: rtl/ea_sum3.sv
module ea_sum3 #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] op_a,
   input  logic [AW-1:0] op_b,
   input  logic [AW-1:0] op_c,
   output logic [AW-1:0] sum
);
   assign sum = op_a + op_b + op_c;
endmodule

// File: rtl/scaled_ea_unit.sv
module scaled_ea_unit
   import ea_pkg::*;
#(
   parameter int AW              = 32,
   parameter int DW              = 32,
   parameter int SDW             = 8,
   parameter int SW              = 2,
   parameter int USE_LOG_SHIFTER = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_mode,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  logic [SW-1:0] scale,
   input  logic [DW-1:0] disp,
   input  logic          disp_wide,
   output logic          res_valid,
   output logic [AW-1:0] res_addr
);
   localparam logic [AW-1:0] ZERO = '0;

   ea_mode_e      mode;
   logic [AW-1:0] idx_scaled;
   logic [AW-1:0] disp_ext;
   logic [AW-1:0] idx_term;
   logic [AW-1:0] disp_term;
   logic [AW-1:0] ea_next;

   assign mode = ea_mode_e'(req_mode);

   ea_index_scaler #(
      .AW(AW), .SW(SW), .USE_LOG_SHIFTER(USE_LOG_SHIFTER)
   ) u_scaler (
      .idx_in (index),
      .shamt  (scale),
      .idx_out(idx_scaled)
   );

   ea_disp_extend #(
      .AW(AW), .DW(DW), .SDW(SDW)
   ) u_disp (
      .disp_in (disp),
      .wide    (disp_wide),
      .disp_out(disp_ext)
   );

   always_comb begin
      idx_term  = ZERO;
      disp_term = ZERO;
      unique case (mode)
         EA_REG_IND:       ;
         EA_BASE_DISP:     disp_term = disp_ext;
         EA_BASE_IDX:      idx_term  = idx_scaled;
         EA_BASE_IDX_DISP: begin
            idx_term  = idx_scaled;
            disp_term = disp_ext;
         end
         default:          ;
      endcase
   end

   ea_sum3 #(.AW(AW)) u_sum (
      .op_a(base),
      .op_b(idx_term),
      .op_c(disp_term),
      .sum (ea_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= ZERO;
      end else begin
         res_valid <= req_valid;
         if (req_valid) res_addr <= ea_next;
      end
   end
endmodule

// File: rtl/ea_checker.sv
module ea_checker #(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int SDW = 8,
   parameter int SW  = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [1:0]    req_mode,
   input logic [AW-1:0] base,
   input logic [AW-1:0] index,
   input logic [SW-1:0] scale,
   input logic [DW-1:0] disp,
   input logic          disp_wide,
   input logic          res_valid,
   input logic [AW-1:0] res_addr
);
   // R2: strobe follows request by one edge
   a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);
   // R9: result holds without a request
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_addr));
   // R3: register indirect passes the base through
   a_r3_indirect: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd0) |=> res_addr == $past(base));
   // R5: short displacement in base+disp mode
   a_r5_short_disp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd1 && !disp_wide) |=>
         res_addr == $past(base) + AW'($signed($past(disp[SDW-1:0]))));
   // R6: scale code 0 adds the bare index
   a_r6_unit_scale: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd2 && scale == '0) |=>
         res_addr == $past(base) + $past(index));
   // R1: reset state
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset: assert (!res_valid && res_addr == '0);
      end
   end
endmodule

bind scaled_ea_unit ea_checker #(.AW(AW), .DW(DW), .SDW(SDW), .SW(SW)) u_ea_chk (.*);

// File: tb/test_scaled_ea_unit.sv
module test_scaled_ea_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_mode = '0;
   logic [31:0] base = '0, index = '0, disp = '0;
   logic [1:0]  scale = '0;
   logic        disp_wide = 1'b0;
   logic        res_valid;
   logic [31:0] res_addr;

   typedef struct {
      logic [31:0] addr;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   logic        seen = 1'b0;
   logic [31:0] last_addr = '0;
   int          cycles = 0;

   always #4 clk = ~clk;

   scaled_ea_unit i_scaled_ea_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .base(base), .index(index), .scale(scale), .disp(disp),
      .disp_wide(disp_wide), .res_valid(res_valid), .res_addr(res_addr)
   );

   function automatic logic [31:0] model(input logic [1:0] m, input logic [31:0] b,
      input logic [31:0] x, input logic [1:0] s, input logic [31:0] d, input logic w);
      longint unsigned acc;
      longint unsigned dv;
      acc = b;
      if (w) dv = {{32{d[31]}}, d};
      else   dv = {{56{d[7]}}, d[7:0]};
      if (m == 2'd2 || m == 2'd3) acc = acc + longint'(x) * (longint'(1) << s);
      if (m == 2'd1 || m == 2'd3) acc = acc + dv;
      return acc[31:0];
   endfunction

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] m, input logic [31:0] b, input logic [31:0] x,
                        input logic [1:0] s, input logic [31:0] d, input logic w,
                        input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_mode = m; base = b; index = x;
      scale = s; disp = d; disp_wide = w;
      e.addr = model(m, b, x, s, d, w);
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         base = $urandom; index = $urandom; disp = $urandom;
         req_mode = 2'($urandom); scale = 2'($urandom);
      end
   endtask

   // monitor: sample 2 ns after each rising edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (res_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2 unexpected strobe", {31'b0, res_valid}, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(res_addr == e.addr, e.tag, res_addr, e.addr);
               last_addr = res_addr;
               seen = 1'b1;
            end
         end else if (seen) begin
            check(res_addr == last_addr, "R9 hold", res_addr, last_addr);
            check(sb.size() == 0, "R2 missing strobe", 32'(sb.size()), 32'd0);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected below 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0 && res_addr == 32'd0, "R1 reset", res_addr, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0 && res_addr == 32'd0, "R1 after release", res_addr, 32'd0);

      // R3: indirect ignores the other terms
      drive(2'd0, 32'h1234_5678, 32'hDEAD_BEEF, 2'd3, 32'hFFFF_FFFF, 1'b1, "R3 indirect");
      drive(2'd0, 32'h0000_0040, 32'h0000_0001, 2'd1, 32'h0000_0080, 1'b0, "R3 indirect");
      // R4 / R5 displacement sizes and short sign bit
      drive(2'd1, 32'h0000_1000, 32'h5555_5555, 2'd2, 32'h0000_0010, 1'b1, "R4 wide disp");
      drive(2'd1, 32'h0000_1000, 32'h0, 2'd0, 32'hABCD_EF7F, 1'b0, "R5 short +127");
      drive(2'd1, 32'h0000_1000, 32'h0, 2'd0, 32'h1234_5680, 1'b0, "R5 short -128");
      drive(2'd1, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_F000, 1'b1, "R5 wide negative");
      idle(2);
      // R6: every scale
      for (int s = 0; s < 4; s++)
         drive(2'd2, 32'h0001_0000, 32'h0000_0003, 2'(s), 32'h7777_7777, 1'b1, "R6 scaled index");
      // R7: all terms
      drive(2'd3, 32'h8000_0000, 32'h0000_0010, 2'd3, 32'hFFFF_FFFC, 1'b0, "R7 full short");
      drive(2'd3, 32'h0000_0100, 32'h0000_0004, 2'd2, 32'h0001_0000, 1'b1, "R7 full wide");
      idle(3);
      // R8: wrap and shifted-out bits
      drive(2'd1, 32'hFFFF_FFF0, 32'h0, 2'd0, 32'h0000_0020, 1'b1, "R8 wrap disp");
      drive(2'd2, 32'h0000_0001, 32'hF000_0001, 2'd3, 32'h0, 1'b0, "R8 index overflow");
      drive(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 32'h0000_00FF, 1'b0, "R8 all negative");
      idle(2);
      // random sweep over modes, scales and sizes
      for (int r = 0; r < 200; r++) begin
         drive(2'($urandom), $urandom, $urandom, 2'($urandom), $urandom, 1'($urandom),
               "R7 random sweep");
         if (r % 7 == 0) idle(1);
      end
      idle(4);
      check(sb.size() == 0, "R2 drained", 32'(sb.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule